// File: doc/BRIEF.md
# Byte Buffer to Nibble Line Transmitter

This block takes frame bytes from an upstream byte buffer and sends them onto a four-bit transmit line. A transmit-enable signal frames the output, and every output moves on the falling edge of the transmit clock. The nominal clock is 25 MHz (40 ns), which gives a 100 Mbit/s line rate. Each byte leaves as two nibbles on two consecutive cycles: the low nibble first, then the high nibble. The block fetches each byte with an active-low read strobe that stays low for one cycle. The byte is latched on the edge where the strobe returns high, and its low nibble goes onto the line on that same edge. This gives one read for every two nibble cycles.

A frame ends at a byte boundary. The frame stops when the byte just read carries the end-of-frame flag, or when the buffer is empty at the moment the next fetch would be made. After a frame ends, the block stays silent for a programmable interframe gap before it begins another frame.

The controller is a five-state machine:
- `S_IDLE` waits for data and moves to `S_START` when the buffer is not empty.
- `S_START` is the strobe cycle for the first byte and always moves to `S_LO`.
- `S_LO` drives the low nibble and always moves to `S_HI`. On that edge it decides whether to fetch the next byte.
- `S_HI` drives the high nibble. It returns to `S_LO` when a byte was fetched and goes to `S_GAP` otherwise.
- `S_GAP` counts the gap and then moves to `S_IDLE`.

Top module: `nib_tx`

## Requirements
- R1: While reset is held low and after it is released with an empty buffer, txen is 0, txd is 0 and buf_rd_n is 1.
- R2: When the block is idle and buf_empty goes low, buf_rd_n goes low on the next falling edge for one cycle. On the falling edge after that, txen rises and txd carries bits [3:0] of the byte read.
- R3: Each byte is sent as bits [3:0] in one cycle, followed immediately by bits [7:4] in the next cycle, with exactly one nibble per cycle while txen is high.
- R4: Inside a frame, buf_rd_n is low for exactly one cycle, only during a high-nibble cycle, and only when another byte follows. The number of reads equals the number of bytes sent.
- R5: A byte read with buf_last high is the final byte of its frame. txen falls on the falling edge after its high nibble, no further byte is read for that frame, and no frame ever ends in the middle of a byte.
- R6: If buf_empty is high at the falling edge that ends a low-nibble cycle, no read is made, and the frame ends after that byte's high nibble, even without an end-of-frame flag.
- R7: While txen is low, txd is 0.
- R8: Between two frames, txen stays low for at least IFG_CYC cycles (default 24). When the buffer already holds the next frame, the gap is exactly IFG_CYC cycles, and no read is made during the gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock; all outputs change on its falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| buf_data | input | 8 | Byte presented by the buffer; must be valid while buf_rd_n is low |
| buf_last | input | 1 | End-of-frame flag that goes with buf_data |
| buf_empty | input | 1 | Buffer holds no byte |
| buf_rd_n | output | 1 | Read strobe, active low; the buffer advances when it rises |
| txd | output | 4 | Transmit nibble |
| txen | output | 1 | Transmit enable; high while nibbles of a frame are on txd |

## Verification
The bench samples every output on the rising edge, half a cycle after the falling edge that changed it. A buffer that turns non-empty while the block is idle is answered by the strobe at the next sample. txen with the low nibble follows one sample later, and the two-cycle start latency is checked at exactly those two rising edges. A buffer model advances its read pointer at the first rising edge after the strobe is released. This keeps buf_empty and buf_data settled before the next falling edge at which the design decides on a fetch. A line monitor rebuilds each byte from nibble pairs, counts the strobes and measures each gap in cycles. Its records are compared against the bytes each scenario pushed, the expected frame lengths and a gap of exactly 24.

// File: rtl/nib_tx_pkg.sv
package nib_tx_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_LO,
        S_HI,
        S_GAP
    } tx_state_t;

endpackage

// File: rtl/nib_tx_gapcnt.sv
module nib_tx_gapcnt #(
    parameter int IFG_CYC = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(IFG_CYC + 1);
    // Low cycles = two edges of leaving plus the count, so stop at IFG_CYC-3
    localparam logic [CW-1:0] LIMIT = CW'(IFG_CYC - 3);

    logic [CW-1:0] cnt_q;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run)
            cnt_q <= '0;
        else if (!done)
            cnt_q <= cnt_q + 1'b1;
    end

    assign done = (cnt_q == LIMIT);

    AST_GAP_CNT_BOUND: assert property (@(negedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= LIMIT)); // R8

endmodule

// File: rtl/nib_tx_datapath.sv
module nib_tx_datapath
    import nib_tx_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_n,
    input  logic [BYTE_W-1:0] buf_data,
    input  logic              buf_last,
    input  tx_state_t         state,
    output logic [BYTE_W/2-1:0] txd,
    output logic              last_q
);
    localparam int NIB_W = BYTE_W / 2;

    logic [BYTE_W-1:0] byte_q;

    // Strobe is low for one cycle; the edge that releases it latches the byte
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_q <= '0;
            last_q <= 1'b0;
        end else if (!rd_n) begin
            byte_q <= buf_data;
            last_q <= buf_last;
        end
    end

    always_comb begin
        unique case (state)
            S_LO:    txd = byte_q[NIB_W-1:0];
            S_HI:    txd = byte_q[BYTE_W-1:NIB_W];
            default: txd = '0;
        endcase
    end

endmodule

// File: rtl/nib_tx_fsm.sv
module nib_tx_fsm
    import nib_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      buf_empty,
    input  logic      last_q,
    input  logic      gap_done,
    output tx_state_t state,
    output logic      rd_n,
    output logic      txen
);
    tx_state_t state_d;
    logic      fetch;
    logic      more_q;
    logic      rd_n_d;

    assign fetch = !last_q && !buf_empty;

    always_comb begin
        state_d = state;
        unique case (state)
            S_IDLE:  if (!buf_empty) state_d = S_START;
            S_START: state_d = S_LO;
            S_LO:    state_d = S_HI;
            S_HI:    state_d = more_q ? S_LO : S_GAP;
            S_GAP:   if (gap_done) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        rd_n_d = !((state == S_IDLE && !buf_empty) || (state == S_LO && fetch));
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            rd_n   <= 1'b1;
            more_q <= 1'b0;
        end else begin
            state <= state_d;
            rd_n  <= rd_n_d;
            if (state == S_LO)
                more_q <= fetch;
        end
    end

    always_comb begin
        unique case (state)
            S_LO, S_HI: txen = 1'b1;
            default:    txen = 1'b0;
        endcase
    end

    AST_STROBE_SINGLE: assert property (@(negedge clk) disable iff (!rst_n)
        !rd_n |=> rd_n); // R4
    AST_LO_THEN_HI: assert property (@(negedge clk) disable iff (!rst_n)
        (state == S_LO) |=> (state == S_HI)); // R3
    AST_LAST_CLOSES: assert property (@(negedge clk) disable iff (!rst_n)
        (state == S_HI && last_q) |=> (state == S_GAP)); // R5
    AST_EMPTY_NO_READ: assert property (@(negedge clk) disable iff (!rst_n)
        (state == S_LO && buf_empty) |=> rd_n); // R6
    AST_TXEN_AFTER_READ: assert property (@(negedge clk) disable iff (!rst_n)
        $rose(txen) |-> $past(!rd_n)); // R2
    AST_NO_READ_IN_GAP: assert property (@(negedge clk) disable iff (!rst_n)
        (state == S_GAP) |-> rd_n); // R8

endmodule

// File: rtl/nib_tx.sv
module nib_tx
    import nib_tx_pkg::*;
#(
    parameter int IFG_CYC = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] buf_data,
    input  logic       buf_last,
    input  logic       buf_empty,
    output logic       buf_rd_n,
    output logic [3:0] txd,
    output logic       txen
);
    tx_state_t state;
    logic      last_q;
    logic      gap_done;

    nib_tx_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .buf_empty (buf_empty),
        .last_q    (last_q),
        .gap_done  (gap_done),
        .state     (state),
        .rd_n      (buf_rd_n),
        .txen      (txen)
    );

    nib_tx_datapath #(.BYTE_W(8)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_n     (buf_rd_n),
        .buf_data (buf_data),
        .buf_last (buf_last),
        .state    (state),
        .txd      (txd),
        .last_q   (last_q)
    );

    nib_tx_gapcnt #(.IFG_CYC(IFG_CYC)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == S_GAP),
        .done  (gap_done)
    );

    AST_IDLE_TXD_ZERO: assert property (@(negedge clk) disable iff (!rst_n)
        !txen |-> (txd == 4'h0)); // R7

endmodule

// File: tb/nib_tx_tb.sv
module nib_tx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] buf_data;
    logic       buf_last;
    logic       buf_empty;
    logic       buf_rd_n;
    logic [3:0] txd;
    logic       txen;

    always #5 clk = ~clk;

    nib_tx #(.IFG_CYC(24)) u_dut (
        .clk(clk), .rst_n(rst_n), .buf_data(buf_data), .buf_last(buf_last),
        .buf_empty(buf_empty), .buf_rd_n(buf_rd_n), .txd(txd), .txen(txen)
    );

    // buffer model
    logic [7:0] mem [64];
    logic       lastf [64];
    int         fill = 0;
    int         rptr = 0;
    assign buf_data  = mem[rptr[5:0]];
    assign buf_last  = lastf[rptr[5:0]];
    assign buf_empty = (rptr == fill);

    // expected stream
    logic [7:0] expb [64];
    int         ecount = 0;

    // line monitor
    logic [7:0] cap [64];
    int capn = 0, nfr = 0, half = 0, lowrun = 1000;
    int fstart [16];
    int fend [16];
    int gap_len [16];
    int rd_count = 0, strobe_bad = 0, idle_bad = 0, partial_bad = 0;
    logic [3:0] lo_nib;
    bit rd_low_prev = 0, txen_prev = 0;

    int checks = 0, failures = 0;
    bit done = 0;

    initial begin
        for (int i = 0; i < 64; i++) begin
            mem[i] = 8'h00;
            lastf[i] = 1'b0;
        end
    end

    always @(posedge clk) begin
        if (rst_n) begin
            if (!buf_rd_n && txen && half == 0) strobe_bad++;
            if (!buf_rd_n && rd_low_prev) strobe_bad++;
            if (!buf_rd_n) rd_count++;
            if (rd_low_prev && buf_rd_n) rptr++;
            rd_low_prev = !buf_rd_n;
            if (txen) begin
                if (!txen_prev) begin
                    gap_len[nfr] = lowrun;
                    fstart[nfr] = capn;
                end
                if (half == 0) begin
                    lo_nib = txd;
                    half = 1;
                end else begin
                    cap[capn[5:0]] = {txd, lo_nib};
                    capn++;
                    half = 0;
                end
            end else begin
                if (txd != 4'h0) idle_bad++;
                if (txen_prev) begin
                    if (half != 0) partial_bad++;
                    half = 0;
                    fend[nfr] = capn;
                    nfr++;
                    lowrun = 1;
                end else begin
                    lowrun++;
                end
            end
            txen_prev = txen;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b, input logic l);
        mem[fill[5:0]] = b;
        lastf[fill[5:0]] = l;
        expb[ecount[5:0]] = b;
        ecount++;
        fill++;
    endtask

    task automatic wait_frames(input int n);
        for (int i = 0; i < 2000 && nfr < n; i++) @(posedge clk);
    endtask

    task automatic check_frame(input int k, input int len, input int e0, input string req);
        chk(fend[k] - fstart[k] == len, req, fend[k] - fstart[k], len);
        for (int i = 0; i < len; i++)
            chk(cap[(fstart[k] + i) % 64] == expb[(e0 + i) % 64], "R3",
                cap[(fstart[k] + i) % 64], expb[(e0 + i) % 64]);
    endtask

    task automatic t_reset;
        repeat (3) @(posedge clk);
        chk(txen == 0, "R1", txen, 0);
        chk(txd == 0, "R1", txd, 0);
        chk(buf_rd_n == 1, "R1", buf_rd_n, 1);
        rst_n = 1'b1;
        repeat (6) @(posedge clk);
        chk(txen == 0 && txd == 0 && buf_rd_n == 1, "R1", {txen, txd, buf_rd_n}, 1);
        chk(rd_count == 0, "R1", rd_count, 0);
    endtask

    task automatic t_basic;
        @(posedge clk);
        push(8'hA5, 0); push(8'h3C, 0); push(8'h0F, 0); push(8'hF0, 1);
        @(posedge clk);
        chk(buf_rd_n == 0 && txen == 0, "R2", {buf_rd_n, txen}, 0);
        @(posedge clk);
        chk(txen == 1, "R2", txen, 1);
        chk(txd == 4'h5, "R2", txd, 5);
        wait_frames(1);
        check_frame(0, 4, 0, "R5");
        chk(rd_count == 4, "R4", rd_count, 4);
        chk(strobe_bad == 0, "R4", strobe_bad, 0);
        repeat (40) @(posedge clk);
    endtask

    task automatic t_single;
        @(posedge clk);
        push(8'h5A, 1);
        wait_frames(2);
        check_frame(1, 1, 4, "R5");
        repeat (40) @(posedge clk);
        chk(rd_count == 5, "R5", rd_count, 5);
    endtask

    task automatic t_empty_end;
        @(posedge clk);
        push(8'h11, 0); push(8'h22, 0); push(8'h33, 0);
        wait_frames(3);
        check_frame(2, 3, 5, "R6");
        repeat (40) @(posedge clk);
        chk(rd_count == 8, "R6", rd_count, 8);
        chk(nfr == 3 && txen == 0, "R6", nfr, 3);
    endtask

    task automatic t_back2back;
        @(posedge clk);
        push(8'hC3, 0); push(8'h7E, 1);
        push(8'h81, 0); push(8'h99, 0); push(8'hE7, 1);
        wait_frames(5);
        check_frame(3, 2, 8, "R5");
        check_frame(4, 3, 10, "R5");
        chk(gap_len[4] == 24, "R8", gap_len[4], 24);
        chk(rd_count == 13, "R8", rd_count, 13);
        repeat (40) @(posedge clk);
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        t_reset;
        t_basic;
        t_single;
        t_empty_end;
        t_back2back;
        chk(idle_bad == 0, "R7", idle_bad, 0);
        chk(partial_bad == 0, "R5", partial_bad, 0);
        chk(strobe_bad == 0, "R4", strobe_bad, 0);
        done = 1;
        summary;
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", nfr, 5);
            summary;
            $finish;
        end
    end

endmodule